// File: doc/BRIEF.md
# Oversampled I2C Target with Control Register File

This block is an I2C target for a small routing-control register file. It samples SCL and SDA with a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter, then through edge detection. A state machine follows each byte on the bus. It matches one of nine 7-bit addresses, picked by two three-level strap inputs. It returns ACK and read data by pulling SDA low through an open-drain enable.

A write transfer has three parts: the address with R/W=0, a command byte that loads the register pointer, and then any number of data bytes. The first data byte goes to the register the pointer names. The pointer then advances by one for each further byte. A transfer that stops right after the command byte changes only the pointer. A read uses the stored pointer, usually after a repeated START. Every byte of the read returns the same register, because the pointer does not move during a read.

The register file has four registers:
- 0x00: read-only status, taken from an input.
- 0x01 and 0x02: two control bytes, driven out as ports.
- 0xFF: an activation register. A write to it produces a one-cycle pulse that carries the written byte.

States of the machine:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte. It goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK`: drives the ACK. It then goes to `ST_RDATA` if R/W=1 and to `ST_CMD` if R/W=0.
- `ST_CMD`: shifts in the command byte, then goes to `ST_CMD_ACK`.
- `ST_CMD_ACK`: drives the ACK, then goes to `ST_WDATA`.
- `ST_WDATA`: shifts in a data byte and writes it, then goes to `ST_WDATA_ACK`.
- `ST_WDATA_ACK`: drives the ACK, then returns to `ST_WDATA`.
- `ST_RDATA`: shifts out a read byte, then goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK`: samples the master's acknowledge. It goes back to `ST_RDATA` on ACK and to `ST_IGNORE` on NACK.
- `ST_IGNORE`: keeps SDA released.

From any state, a START goes to `ST_ADDR` and a STOP goes to `ST_IDLE`.

Top module: `i2c_regmap_target`

## Requirements
- R1: Each strap input is coded 00=low, 01=open, 10=high; 11 counts as open. The target ACKs the address 7'h50 + 3*level(sel0) + level(sel1), where low=0, open=1, high=2. This gives 8-bit write addresses 0xA0 to 0xB0 in steps of 2. ACK means sda_oe=1 while SCL is high in the ninth bit.
- R2: After an address that does not match, SDA stays released (sda_oe=0) for every following bit until the next START.
- R3: The command byte loads the pointer. A STOP right after the command byte leaves every register unchanged. The loaded pointer is then used by the next read.
- R4: Data bytes are written starting at the pointer, and the pointer advances by one after each byte. Register 0x01 drives ctrl_a and register 0x02 drives ctrl_b.
- R5: Read bytes are shifted out MSB first. Every byte of one read returns the same register. A master NACK ends the read, and SDA then stays released.
- R6: A repeated START keeps the pointer that the command byte set earlier in the same transfer.
- R7: Register 0x00 reads status_in. Writes to 0x00 are ACKed and have no effect.
- R8: A write to 0xFF raises act_pulse for exactly one clock, with act_data equal to the written byte. Reads of 0xFF, and of any address other than 0x00 to 0x02, return 0x00. Writes to unmapped addresses have no effect.
- R9: A pulse on SCL shorter than FILT_LEN system clocks has no effect on the bits received.
- R10: After reset, ctrl_a = ctrl_b = 0x00, act_pulse = 0 and sda_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel0 | input | 2 | First three-level address strap |
| addr_sel1 | input | 2 | Second three-level address strap |
| status_in | input | 8 | Value returned by register 0x00 |
| ctrl_a | output | 8 | Control register 0x01 |
| ctrl_b | output | 8 | Control register 0x02 |
| act_pulse | output | 1 | One-cycle strobe on a write to 0xFF |
| act_data | output | 8 | Byte written to 0xFF |

## Verification
In a single clock edge, the SCL fall that ends a data byte both issues the register write and advances the pointer. A STOP placed directly after the command ACK must store the pointer without producing any write strobe. The bench provokes both cases. It writes several bytes in one burst, and it sends a command-only transfer followed by a separate read. Results are judged at the control ports and through the read data: the read data shows that the pointer was stored and was not advanced, and the control ports stay unchanged after the command-only transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tgt_state_e;

    localparam logic [7:0] REG_STATUS = 8'h00;
    localparam logic [7:0] REG_CTRL_A = 8'h01;
    localparam logic [7:0] REG_CTRL_B = 8'h02;
    localparam logic [7:0] REG_ACT    = 8'hFF;
    localparam logic [6:0] ADDR_BASE  = 7'h50;

    function automatic logic [1:0] strap_level(input logic [1:0] s);
        case (s)
            2'b00:   strap_level = 2'd0;
            2'b10:   strap_level = 2'd2;
            default: strap_level = 2'd1;
        endcase
    endfunction

    function automatic logic [6:0] strap_addr(input logic [1:0] s0, input logic [1:0] s1);
        logic [6:0] l0;
        logic [6:0] l1;
        l0 = {5'd0, strap_level(s0)};
        l1 = {5'd0, strap_level(s1)};
        strap_addr = ADDR_BASE + 7'd3 * l0 + l1;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            run_q  <= '0;
            dout   <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            if (sync_q == dout) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                run_q <= '0;
                dout  <= sync_q;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R9: the filtered line only ever takes a value the synchronizer already held
    assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> dout == $past(sync_q));

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    input  logic [7:0] status_in,
    output logic [7:0] rd_data,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b,
    output logic       act_pulse,
    output logic [7:0] act_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a    <= '0;
            ctrl_b    <= '0;
            act_pulse <= 1'b0;
            act_data  <= '0;
        end else begin
            act_pulse <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    REG_CTRL_A: ctrl_a <= wr_data;
                    REG_CTRL_B: ctrl_b <= wr_data;
                    REG_ACT: begin
                        act_pulse <= 1'b1;
                        act_data  <= wr_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            REG_STATUS: rd_data = status_in;
            REG_CTRL_A: rd_data = ctrl_a;
            REG_CTRL_B: rd_data = ctrl_b;
            default:    rd_data = 8'h00;
        endcase
    end

    assert_status_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_STATUS) |=> ($stable(ctrl_a) && $stable(ctrl_b)));

    assert_act_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |=> !act_pulse);

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [6:0] own_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    tgt_state_e state, nxt;

    logic       scl_d, sda_d;
    logic [7:0] sr;
    logic [7:0] tx;
    logic [3:0] cnt;
    logic       rw;
    logic       nack;

    wire scl_rise = scl & ~scl_d;
    wire scl_fall = ~scl & scl_d;
    wire start_c  = scl & scl_d & sda_d & ~sda;
    wire stop_c   = scl & scl_d & ~sda_d & sda;
    wire byte_end = scl_fall && (cnt == 4'd8);
    wire hit      = (sr[7:1] == own_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start_c) begin
            nxt = ST_ADDR;
        end else if (stop_c) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      ;
                ST_ADDR:      if (byte_end) nxt = hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_end) nxt = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_end) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (byte_end) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = nack ? ST_IGNORE : ST_RDATA;
                ST_IGNORE:    ;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            sr      <= '0;
            tx      <= '0;
            cnt     <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            wr_en <= 1'b0;
            if (scl_rise) begin
                if (state == ST_ADDR || state == ST_CMD || state == ST_WDATA) begin
                    sr  <= {sr[6:0], sda};
                    cnt <= cnt + 1'b1;
                end else if (state == ST_RDATA) begin
                    cnt <= cnt + 1'b1;
                end else if (state == ST_RDATA_ACK) begin
                    nack <= sda;
                end
            end
            if (start_c) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                sda_oe <= 1'b0;
            end else if (scl_fall) begin
                case (state)
                    ST_ADDR: if (byte_end) begin
                        cnt <= '0;
                        rw  <= sr[0];
                        if (hit) sda_oe <= 1'b1;
                    end
                    ST_ADDR_ACK: begin
                        cnt <= '0;
                        if (rw) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_CMD: if (byte_end) begin
                        ptr    <= sr;
                        sda_oe <= 1'b1;
                        cnt    <= '0;
                    end
                    ST_WDATA: if (byte_end) begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= sr;
                        ptr     <= ptr + 1'b1;
                        sda_oe  <= 1'b1;
                        cnt     <= '0;
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: sda_oe <= 1'b0;
                    ST_RDATA: begin
                        if (cnt == 4'd8) sda_oe <= 1'b0;
                        else             sda_oe <= ~tx[3'd7 - cnt[2:0]];
                    end
                    ST_RDATA_ACK: begin
                        cnt <= '0;
                        if (!nack) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_released_when_ignoring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

    assert_write_only_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> state == ST_WDATA_ACK);

    assert_ptr_fixed_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA || state == ST_RDATA_ACK) |-> $stable(ptr));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
    import i2c_tgt_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [1:0] addr_sel0,
    input  logic [1:0] addr_sel1,
    input  logic [7:0] status_in,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b,
    output logic       act_pulse,
    output logic [7:0] act_data
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic [7:0]        ptr, rd_data, wr_addr, wr_data;
    logic              wr_en;
    logic [6:0]        own_addr;

    assign raw_lines = {sda_in, scl_in};
    assign own_addr  = strap_addr(addr_sel0, addr_sel1);

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (clean_lines[g])
        );
    end

    i2c_tgt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .own_addr(own_addr),
        .rd_data (rd_data),
        .ptr     (ptr),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    i2c_tgt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .status_in(status_in),
        .rd_data  (rd_data),
        .ctrl_a   (ctrl_a),
        .ctrl_b   (ctrl_b),
        .act_pulse(act_pulse),
        .act_data (act_data)
    );

endmodule

// File: tb/i2c_regmap_target_test.sv
module i2c_regmap_target_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] sel0 = 2'b00;
    logic [1:0] sel1 = 2'b00;
    logic [7:0] status = 8'h5E;
    logic       sda_oe, act_pulse;
    logic [7:0] ctrl_a, ctrl_b, act_data;
    wire        sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int act_cnt = 0;
    logic [7:0] act_last = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_regmap_target uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .addr_sel0(sel0), .addr_sel1(sel1), .status_in(status),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .act_pulse(act_pulse), .act_data(act_data)
    );

    always @(posedge clk) if (act_pulse) begin
        act_cnt  <= act_cnt + 1;
        act_last <= act_data;
    end

    // {expect_ack, sel0, sel1, addr7}
    localparam logic [11:0] VEC [0:11] = '{
        {1'b1, 2'b00, 2'b00, 7'h50}, {1'b1, 2'b00, 2'b01, 7'h51},
        {1'b1, 2'b00, 2'b10, 7'h52}, {1'b1, 2'b01, 2'b00, 7'h53},
        {1'b1, 2'b01, 2'b01, 7'h54}, {1'b1, 2'b10, 2'b01, 7'h57},
        {1'b1, 2'b10, 2'b10, 7'h58}, {1'b1, 2'b11, 2'b11, 7'h54},
        {1'b0, 2'b00, 2'b00, 7'h51}, {1'b0, 2'b10, 2'b10, 7'h50},
        {1'b0, 2'b01, 2'b01, 7'h58}, {1'b0, 2'b00, 2'b10, 7'h28}
    };

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        wait_c(10); sda_m = 1'b1;
        wait_c(10); scl = 1'b1;
        wait_c(20); sda_m = 1'b0;
        wait_c(20); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_c(10); sda_m = 1'b0;
        wait_c(10); scl = 1'b1;
        wait_c(20); sda_m = 1'b1;
        wait_c(20);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wait_c(10); sda_m = b[i];
            wait_c(10); scl = 1'b1;
            if (glitch && i == 3) begin
                wait_c(8); scl = 1'b0;
                wait_c(2); scl = 1'b1;
                wait_c(10);
            end else begin
                wait_c(20);
            end
            scl = 1'b0;
        end
        wait_c(10); sda_m = 1'b1;
        wait_c(10); scl = 1'b1;
        wait_c(10); ack = (sda_bus == 1'b0);
        wait_c(10); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_c(20); scl = 1'b1;
            wait_c(10); b[i] = sda_bus;
            wait_c(10); scl = 1'b0;
        end
        wait_c(10); sda_m = give_ack ? 1'b0 : 1'b1;
        wait_c(10); scl = 1'b1;
        wait_c(20); scl = 1'b0;
    endtask

    localparam logic [7:0] WADDR = 8'hA0;
    localparam logic [7:0] RADDR = 8'hA1;

    initial begin
        bit a;
        bit a2;
        logic [7:0] d;
        logic [7:0] d2;
        int act_before;

        wait_c(5);
        check(sda_oe == 1'b0 && ctrl_a == 8'h00 && ctrl_b == 8'h00 && act_pulse == 1'b0,
              "R10 reset state", {ctrl_a, ctrl_b}, 0);
        rst_n = 1'b1;
        wait_c(10);

        for (int k = 0; k < 12; k++) begin
            sel0 = VEC[k][8:7];
            sel1 = VEC[k][10:9] == 2'b00 ? VEC[k][8:7] : VEC[k][8:7];
            sel0 = VEC[k][10:9];
            sel1 = VEC[k][8:7];
            wait_c(10);
            bus_start();
            send_byte({VEC[k][6:0], 1'b0}, 1'b0, a);
            if (VEC[k][11]) begin
                check(a == 1'b1, "R1 strap address ACK", a, 1);
            end else begin
                send_byte(8'h00, 1'b0, a2);
                check(a == 1'b0 && a2 == 1'b0, "R2 mismatch keeps SDA released", {a, a2}, 0);
            end
            bus_stop();
        end

        sel0 = 2'b00; sel1 = 2'b00;
        wait_c(10);

        // R4: burst write through pointer 0x01 then 0x02
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        send_byte(8'h3C, 1'b0, a);
        send_byte(8'hA5, 1'b0, a2);
        bus_stop();
        check(ctrl_a == 8'h3C && ctrl_b == 8'hA5 && a && a2, "R4 auto-increment write",
              {ctrl_a, ctrl_b}, 16'h3CA5);

        // R3: command byte only, then stop
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'h02, 1'b0, a);
        bus_stop();
        check(ctrl_a == 8'h3C && ctrl_b == 8'hA5, "R3 command-only leaves registers",
              {ctrl_a, ctrl_b}, 16'h3CA5);

        // R5: read twice from stored pointer 0x02
        bus_start();
        send_byte(RADDR, 1'b0, a);
        recv_byte(1'b1, d);
        recv_byte(1'b0, d2);
        check(d == 8'hA5, "R3 stored pointer used by read", d, 8'hA5);
        check(d2 == 8'hA5, "R5 pointer fixed across read bytes", d2, 8'hA5);
        wait_c(30);
        check(sda_oe == 1'b0, "R5 SDA released after NACK", sda_oe, 0);
        bus_stop();

        // R7: write to status is acknowledged but discarded
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h77, 1'b0, a2);
        bus_stop();
        check(a2 == 1'b1 && ctrl_a == 8'h3C && ctrl_b == 8'hA5, "R7 status write ignored",
              {a2, ctrl_a, ctrl_b}, {1'b1, 16'h3CA5});

        // R6, R7: pointer 0x00 then repeated START read
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        bus_start();
        send_byte(RADDR, 1'b0, a);
        recv_byte(1'b0, d);
        bus_stop();
        check(d == 8'h5E, "R6 repeated START keeps pointer / R7 status read", d, 8'h5E);

        // R8: activation write pulse and zero read-back
        act_before = act_cnt;
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'hFF, 1'b0, a);
        send_byte(8'h99, 1'b0, a);
        bus_stop();
        check(act_cnt == act_before + 1 && act_last == 8'h99, "R8 activation pulse",
              {act_cnt[7:0], act_last}, {8'(act_before + 1), 8'h99});
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'hFF, 1'b0, a);
        bus_start();
        send_byte(RADDR, 1'b0, a);
        recv_byte(1'b0, d);
        bus_stop();
        check(d == 8'h00, "R8 activation reads zero", d, 0);

        // R8: unmapped write beyond 0x02 has no effect
        act_before = act_cnt;
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        send_byte(8'h11, 1'b0, a);
        send_byte(8'h22, 1'b0, a);
        send_byte(8'h33, 1'b0, a);
        bus_stop();
        check(ctrl_a == 8'h11 && ctrl_b == 8'h22 && act_cnt == act_before,
              "R8 write past map discarded", {ctrl_a, ctrl_b}, 16'h1122);

        // R9: short SCL glitch inside a data bit
        bus_start();
        send_byte(WADDR, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        send_byte(8'h6B, 1'b1, a2);
        bus_stop();
        check(ctrl_a == 8'h6B && a2 == 1'b1, "R9 SCL glitch filtered", ctrl_a, 8'h6B);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule